// File: doc/BRIEF.md
# SD Command Path Checker

This block drives the command line of an SD host and judges what comes back. A start pulse loads a command index and a 32-bit argument. The block builds a 48-bit command frame with its CRC7 and sends it one bit per SDCLK cycle, most significant bit first. While it drives a 1, it compares the line level seen at the following edge against the level it drove. A low reading means another device is pulling the line, so the block releases the line at once and abandons the command.

When a response is expected, the block watches the idle line for a start bit for a bounded number of cycles after the command's end bit. It then shifts in the 48-bit response and checks it for three faults: a CRC mismatch, a zero end bit, and an index that differs from the one sent. Each outcome sets a bit in a sticky status vector that software clears by writing ones. One pulse marks a finished command and another marks an abandoned one. The fifth status bit only latches an external data-timeout indication.

The block is clocked by SDCLK: every rising clock edge is one command-line bit time.

Top module: `sd_cmd_chk`

## Requirements
- R1: A start accepted in idle makes the block drive `cmd_oe_o` high for exactly 48 cycles. During those cycles it sends the frame on `cmd_out_o`, most significant bit first, in this order:
  - frame bit 47 = 0
  - bit 46 = 1
  - bits 45:40 = index
  - bits 39:8 = argument
  - bits 7:1 = CRC7 (generator x^7+x^3+1, zero initial value) computed over frame bits 47:8
  - bit 0 = 1
- R2: If the block drives a 1 and `cmd_line_i` reads 0 at the next rising edge, `cmd_oe_o` is low from the following cycle onward, `abort_o` pulses for one cycle, and no `done_o` pulse is produced for that command.
- R3: A line conflict sets status bit 0 (command timeout) and status bit 1 (command CRC) together, in the same cycle as `abort_o`, without waiting for any response window.
- R4: With a response expected, the line is sampled at each of the 64 rising edges that follow the edge ending the command's end bit. If all 64 samples are 1, status bit 0 is set and `done_o` pulses in the next cycle. A start bit (0) seen at the 64th sample is still accepted as a response.
- R5: Status bit 1 is set when the 7 received CRC bits (response bits 7:1) differ from the CRC7 of response bits 47:8. This check applies only to a response that was received, never to a timeout.
- R6: Status bit 2 is set when the last received response bit (bit 0) is 0.
- R7: Status bit 3 is set when response bits 45:40 differ from the index of the issued command.
- R8: Status bit 4 is set in the cycle after `dat_tout_i` is high.
- R9: All status bits are 0 after reset. A status bit stays 1 until the cycle after a 1 is written to its position of `err_clr_i`. A 0 in `err_clr_i` leaves the bit unchanged. A new error wins over a clear written in the same cycle.
- R10: A start pulse while a command is being sent or awaited is ignored: the frame on the line is unchanged by it, and no extra completion follows.
- R11: With no response expected, `done_o` pulses in the cycle right after the edge that ends the end bit, and the status vector is unchanged.
- R12: After a received response, `done_o` pulses for one cycle in the cycle after the edge that sampled the response end bit, with the status already updated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | SDCLK; one command-line bit per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to send a command |
| cmd_idx_i | input | 6 | Command index to send |
| cmd_arg_i | input | 32 | Command argument to send |
| resp_exp_i | input | 1 | 1 = a response is awaited after the command |
| cmd_line_i | input | 1 | Sampled level of the CMD line |
| dat_tout_i | input | 1 | External data-timeout indication, latched into status bit 4 |
| err_clr_i | input | 5 | Write-one-to-clear mask for the status bits |
| cmd_out_o | output | 1 | Level driven onto the CMD line |
| cmd_oe_o | output | 1 | Drive enable for the CMD line |
| err_sts_o | output | 5 | Sticky status: bit 0 command timeout, bit 1 command CRC, bit 2 end bit, bit 3 index, bit 4 data timeout |
| done_o | output | 1 | One-cycle pulse when a command finishes |
| abort_o | output | 1 | One-cycle pulse when a command is abandoned on a line conflict |

## Verification
Commands are sent with several index and argument pairs, and every driven bit is compared with an independently computed frame. This separates framing and CRC faults from response-side faults. Responses arrive after gaps of 0, 63 and 64 idle samples, which pins down where the 64-sample window ends. Responses with a flipped CRC bit, a zero end bit, or a wrong index each select exactly one status bit. A line pulled low under a driven 1 must produce an abort with the paired timeout and CRC bits, not a completion. Further stimuli cover a start issued mid-frame, a data-timeout pulse, and partial clear masks, to show what is ignored and what stays sticky.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;

  localparam int FRAME_W = 48;
  localparam int IDX_W   = 6;
  localparam int ARG_W   = 32;
  localparam int CRC_W   = 7;
  localparam int HEAD_W  = FRAME_W - CRC_W - 1;
  localparam int ERR_W   = 5;

  localparam int E_CTO  = 0;
  localparam int E_CCRC = 1;
  localparam int E_CEND = 2;
  localparam int E_CIDX = 3;
  localparam int E_DTO  = 4;

  typedef enum logic [1:0] {
    RS_IDLE = 2'd0,
    RS_WAIT = 2'd1,
    RS_RECV = 2'd2
  } rsp_state_e;

  function automatic logic [CRC_W-1:0] crc7_of(input logic [HEAD_W-1:0] d);
    logic [CRC_W-1:0] c;
    logic fb;
    c = '0;
    for (int i = HEAD_W - 1; i >= 0; i--) begin
      fb = d[i] ^ c[CRC_W-1];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

endpackage

// File: rtl/sd_cmd_ser.sv
module sd_cmd_ser
  import sd_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [ARG_W-1:0] arg_i,
  input  logic             line_i,
  output logic             cmd_o,
  output logic             oe_o,
  output logic             fin_o,
  output logic             clash_o
);

  localparam int CNT_W = $clog2(FRAME_W);

  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               act_q, act_d;
  logic [HEAD_W-1:0]  head;

  assign head = {1'b0, 1'b1, idx_i, arg_i};

  assign clash_o = act_q && sh_q[FRAME_W-1] && !line_i;
  assign fin_o   = act_q && !clash_o && (cnt_q == CNT_W'(FRAME_W - 1));

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    act_d = act_q;
    if (!act_q) begin
      if (load_i) begin
        sh_d  = {head, crc7_of(head), 1'b1};
        cnt_d = '0;
        act_d = 1'b1;
      end
    end else if (clash_o || fin_o) begin
      act_d = 1'b0;
    end else begin
      sh_d  = {sh_q[FRAME_W-2:0], 1'b1};
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '1;
      cnt_q <= '0;
      act_q <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign cmd_o = act_q ? sh_q[FRAME_W-1] : 1'b1;
  assign oe_o  = act_q;

  // R2
  conflict_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clash_o |=> !oe_o);

  // R1
  start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_o) |-> (cmd_o == 1'b0));

endmodule

// File: rtl/sd_cmd_rsp.sv
module sd_cmd_rsp
  import sd_cmd_pkg::*;
#(
  parameter int WIN = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             line_i,
  output logic             busy_o,
  output logic             fin_o,
  output logic             tout_o,
  output logic             crc_err_o,
  output logic             end_err_o,
  output logic             idx_err_o
);

  localparam int WCW   = (WIN > 1) ? $clog2(WIN) : 1;
  localparam int RBITS = FRAME_W - 1;
  localparam int RCW   = $clog2(RBITS);

  rsp_state_e         st_q, st_d;
  logic [WCW-1:0]     wcnt_q, wcnt_d;
  logic [RCW-1:0]     rcnt_q, rcnt_d;
  logic [RBITS-2:0]   sh_q, sh_d;
  logic [RBITS-1:0]   full;
  logic [CRC_W-1:0]   crc_calc;

  assign full     = {sh_q, line_i};
  assign crc_calc = crc7_of({1'b0, full[RBITS-1:CRC_W+1]});

  assign tout_o    = (st_q == RS_WAIT) && line_i && (wcnt_q == WCW'(WIN - 1));
  assign fin_o     = (st_q == RS_RECV) && (rcnt_q == RCW'(RBITS - 1));
  assign crc_err_o = fin_o && (full[CRC_W:1] != crc_calc);
  assign end_err_o = fin_o && !line_i;
  assign idx_err_o = fin_o && (full[RBITS-2 -: IDX_W] != idx_i);
  assign busy_o    = (st_q != RS_IDLE);

  always_comb begin
    st_d   = st_q;
    wcnt_d = wcnt_q;
    rcnt_d = rcnt_q;
    sh_d   = sh_q;
    case (st_q)
      RS_IDLE: begin
        if (arm_i) begin
          st_d   = RS_WAIT;
          wcnt_d = '0;
        end
      end
      RS_WAIT: begin
        if (!line_i) begin
          st_d   = RS_RECV;
          rcnt_d = '0;
        end else if (tout_o) begin
          st_d = RS_IDLE;
        end else begin
          wcnt_d = wcnt_q + 1'b1;
        end
      end
      RS_RECV: begin
        sh_d = {sh_q[RBITS-3:0], line_i};
        if (fin_o) st_d = RS_IDLE;
        else       rcnt_d = rcnt_q + 1'b1;
      end
      default: st_d = RS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RS_IDLE;
      wcnt_q <= '0;
      rcnt_q <= '0;
      sh_q   <= '0;
    end else begin
      st_q   <= st_d;
      wcnt_q <= wcnt_d;
      rcnt_q <= rcnt_d;
      sh_q   <= sh_d;
    end
  end

  // R4
  wait_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tout_o |=> (st_q == RS_IDLE));

  // R5
  crc_only_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crc_err_o |-> !tout_o);

endmodule

// File: rtl/sd_err_sts.sv
module sd_err_sts
  import sd_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ERR_W-1:0] set_i,
  input  logic [ERR_W-1:0] clr_i,
  output logic [ERR_W-1:0] sts_o
);

  logic [ERR_W-1:0] sts_q, sts_d;

  always_comb begin
    sts_d = (sts_q & ~clr_i) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= sts_d;
  end

  assign sts_o = sts_q;

  // R9
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sts_q & ($past(sts_q) & ~$past(clr_i))) == ($past(sts_q) & ~$past(clr_i))));

endmodule

// File: rtl/sd_cmd_chk.sv
module sd_cmd_chk
  import sd_cmd_pkg::*;
#(
  parameter int RESP_WIN = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [5:0]       cmd_idx_i,
  input  logic [31:0]      cmd_arg_i,
  input  logic             resp_exp_i,
  input  logic             cmd_line_i,
  input  logic             dat_tout_i,
  input  logic [4:0]       err_clr_i,
  output logic             cmd_out_o,
  output logic             cmd_oe_o,
  output logic [4:0]       err_sts_o,
  output logic             done_o,
  output logic             abort_o
);

  logic             idle, load;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             rexp_q, rexp_d;
  logic             done_q, done_d, abort_q, abort_d;
  logic             tx_oe, tx_fin, tx_clash;
  logic             rx_busy, rx_fin, rx_tout, rx_crc, rx_end, rx_idx;
  logic [ERR_W-1:0] set_vec;

  assign idle = !tx_oe && !rx_busy;
  assign load = start_i && idle;

  sd_cmd_ser u_ser (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load),
    .idx_i   (cmd_idx_i),
    .arg_i   (cmd_arg_i),
    .line_i  (cmd_line_i),
    .cmd_o   (cmd_out_o),
    .oe_o    (tx_oe),
    .fin_o   (tx_fin),
    .clash_o (tx_clash)
  );

  sd_cmd_rsp #(.WIN(RESP_WIN)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm_i     (tx_fin && rexp_q),
    .idx_i     (idx_q),
    .line_i    (cmd_line_i),
    .busy_o    (rx_busy),
    .fin_o     (rx_fin),
    .tout_o    (rx_tout),
    .crc_err_o (rx_crc),
    .end_err_o (rx_end),
    .idx_err_o (rx_idx)
  );

  always_comb begin
    set_vec         = '0;
    set_vec[E_CTO]  = tx_clash || rx_tout;
    set_vec[E_CCRC] = tx_clash || rx_crc;
    set_vec[E_CEND] = rx_end;
    set_vec[E_CIDX] = rx_idx;
    set_vec[E_DTO]  = dat_tout_i;
  end

  sd_err_sts u_sts (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (set_vec),
    .clr_i (err_clr_i),
    .sts_o (err_sts_o)
  );

  always_comb begin
    idx_d   = load ? cmd_idx_i  : idx_q;
    rexp_d  = load ? resp_exp_i : rexp_q;
    done_d  = (tx_fin && !rexp_q) || rx_fin || rx_tout;
    abort_d = tx_clash;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      rexp_q  <= 1'b0;
      done_q  <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      idx_q   <= idx_d;
      rexp_q  <= rexp_d;
      done_q  <= done_d;
      abort_q <= abort_d;
    end
  end

  assign cmd_oe_o = tx_oe;
  assign done_o   = done_q;
  assign abort_o  = abort_q;

  // R3
  clash_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> (err_sts_o[1:0] == 2'b11));

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R2
  done_abort_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && abort_o));

  // R10
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !idle) |=> $stable(idx_q));

endmodule

// File: tb/sd_cmd_chk_bench.sv
module sd_cmd_chk_bench;

  typedef struct packed {
    logic       is_abort;
    logic [4:0] err;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [5:0]  cmd_idx_i = '0;
  logic [31:0] cmd_arg_i = '0;
  logic        resp_exp_i = 1'b0;
  logic        dat_tout_i = 1'b0;
  logic [4:0]  err_clr_i = '0;
  logic        resp_line = 1'b1;
  logic        force_low = 1'b0;
  logic        cmd_line_i;
  logic        cmd_out_o, cmd_oe_o, done_o, abort_o;
  logic [4:0]  err_sts_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  exp_t exp_q[$];

  always #4 clk = ~clk;

  assign cmd_line_i = cmd_oe_o ? (cmd_out_o & ~force_low) : resp_line;

  sd_cmd_chk u_sd_cmd_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .cmd_idx_i  (cmd_idx_i),
    .cmd_arg_i  (cmd_arg_i),
    .resp_exp_i (resp_exp_i),
    .cmd_line_i (cmd_line_i),
    .dat_tout_i (dat_tout_i),
    .err_clr_i  (err_clr_i),
    .cmd_out_o  (cmd_out_o),
    .cmd_oe_o   (cmd_oe_o),
    .err_sts_o  (err_sts_o),
    .done_o     (done_o),
    .abort_o    (abort_o)
  );

  function automatic logic [6:0] ref_crc(input logic [39:0] d);
    logic [46:0] r;
    r = {d, 7'b0};
    for (int i = 46; i >= 7; i--)
      if (r[i]) r[i -: 8] = r[i -: 8] ^ 8'b1000_1001;
    return r[6:0];
  endfunction

  function automatic logic [47:0] mk_frame(input logic tbit, input logic [5:0] idx,
                                           input logic [31:0] arg);
    logic [39:0] h;
    h = {1'b0, tbit, idx, arg};
    return {h, ref_crc(h), 1'b1};
  endfunction

  task automatic check(input string tag, input logic [47:0] act, input logic [47:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && (done_o || abort_o)) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R10 unexpected completion actual=%0h expected=none",
                 {abort_o, err_sts_o});
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check("R12 completion/status", {42'b0, abort_o, err_sts_o}, {42'b0, e});
      end
    end
  end

  task automatic clear_all();
    err_clr_i = 5'h1f;
    @(negedge clk);
    err_clr_i = '0;
    check("R9 cleared status", {43'b0, err_sts_o}, 48'h0);
  endtask

  // mode: 0 good, 1 crc flip, 2 end bit 0, 3 wrong index
  task automatic run_cmd(input logic [5:0] idx, input logic [31:0] arg, input logic rexp,
                         input int gap, input int mode, input int cpos, input bit intr,
                         input logic [4:0] exp_err, input string tag);
    logic [47:0] fr, rsp, seen;
    exp_t e;
    bit aborted;
    aborted = 1'b0;
    fr = mk_frame(1'b1, idx, arg);
    e.is_abort = (cpos >= 0);
    e.err = exp_err;
    exp_q.push_back(e);
    cmd_idx_i = idx; cmd_arg_i = arg; resp_exp_i = rexp; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    seen = '0;
    for (int i = 0; i < 48; i++) begin
      if (i > 0) @(negedge clk);
      seen[47-i] = cmd_oe_o ? cmd_out_o : 1'bx;
      if (intr && i == 10) begin start_i = 1'b1; cmd_idx_i = idx ^ 6'h3f; end
      if (intr && i == 11) begin start_i = 1'b0; cmd_idx_i = idx; end
      if (i == cpos) begin
        force_low = 1'b1;
        @(negedge clk);
        force_low = 1'b0;
        check("R2 line released after conflict", {47'b0, cmd_oe_o}, 48'h0);
        aborted = 1'b1;
        break;
      end
    end
    if (aborted) begin
      repeat (3) @(negedge clk);
      return;
    end
    check({tag, " R1 frame"}, seen, fr);
    @(negedge clk);
    check("R1 drive ends after 48 bits", {47'b0, cmd_oe_o}, 48'h0);
    if (!rexp) begin
      check("R11 done right after end bit", {47'b0, done_o}, 48'h1);
      @(negedge clk);
      return;
    end
    for (int j = 0; j < gap && j < 64; j++) begin
      resp_line = 1'b1;
      @(negedge clk);
    end
    if (gap >= 64) begin
      check("R4 timeout done", {47'b0, done_o}, 48'h1);
      @(negedge clk);
      return;
    end
    begin
      logic [39:0] h;
      h = {1'b0, 1'b0, (mode == 3) ? (idx ^ 6'h01) : idx, ~arg};
      rsp = {h, ref_crc(h), 1'b1};
      if (mode == 1) rsp[3] = ~rsp[3];
      if (mode == 2) rsp[0] = 1'b0;
    end
    for (int b = 47; b >= 0; b--) begin
      resp_line = rsp[b];
      @(negedge clk);
    end
    resp_line = 1'b1;
    check({tag, " R12 done after response"}, {47'b0, done_o}, 48'h1);
    @(negedge clk);
    check("R12 done one cycle", {47'b0, done_o}, 48'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset status", {43'b0, err_sts_o}, 48'h0);
    check("R1 idle no drive", {47'b0, cmd_oe_o}, 48'h0);
    rst_n = 1'b1;
    @(negedge clk);

    run_cmd(6'd17, 32'h1234_5678, 1'b1, 2, 0, -1, 1'b0, 5'h00, "R1 good A");
    run_cmd(6'd55, 32'hA5A5_0F0F, 1'b1, 0, 0, -1, 1'b0, 5'h00, "R1 good B gap0");
    run_cmd(6'd8,  32'h0000_01AA, 1'b1, 63, 0, -1, 1'b0, 5'h00, "R4 gap63 accepted");
    run_cmd(6'd2,  32'hFFFF_FFFF, 1'b1, 64, 0, -1, 1'b0, 5'h01, "R4 timeout");
    clear_all();
    run_cmd(6'd13, 32'hDEAD_BEEF, 1'b1, 5, 1, -1, 1'b0, 5'h02, "R5 crc");
    clear_all();
    run_cmd(6'd13, 32'h0BAD_F00D, 1'b1, 5, 2, -1, 1'b0, 5'h04, "R6 end bit");
    clear_all();
    run_cmd(6'd41, 32'h7777_0001, 1'b1, 5, 3, -1, 1'b0, 5'h08, "R7 index");
    clear_all();
    run_cmd(6'd0,  32'h0000_0000, 1'b0, 0, 0, -1, 1'b0, 5'h00, "R11 no response");
    run_cmd(6'd24, 32'hCAFE_1234, 1'b1, 3, 0, 1, 1'b0, 5'h03, "R3 conflict");
    check("R3 conflict pair", {43'b0, err_sts_o}, 48'h03);
    clear_all();
    run_cmd(6'd9, 32'h1357_9BDF, 1'b1, 4, 0, -1, 1'b1, 5'h00, "R10 start ignored");

    dat_tout_i = 1'b1;
    @(negedge clk);
    dat_tout_i = 1'b0;
    check("R8 data timeout latched", {43'b0, err_sts_o}, 48'h10);
    run_cmd(6'd3, 32'h0000_0002, 1'b1, 64, 0, -1, 1'b0, 5'h11, "R9 sticky with timeout");
    err_clr_i = 5'h01;
    @(negedge clk);
    err_clr_i = '0;
    check("R9 partial clear keeps bit4", {43'b0, err_sts_o}, 48'h10);
    err_clr_i = 5'h10;
    dat_tout_i = 1'b1;
    @(negedge clk);
    err_clr_i = '0; dat_tout_i = 1'b0;
    check("R9 set wins over clear", {43'b0, err_sts_o}, 48'h10);
    clear_all();

    repeat (4) @(negedge clk);
    check("R10 no pending completions", {16'b0, 32'(exp_q.size())}, 48'h0);
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule